// File: doc/BRIEF.md
# Remote terminal status word controller

This block assembles the 20-bit-time status response of a serial avionics bus remote terminal and runs the status-related handshake with the attached subsystem. When a decoded command arrives (falling edge of `cmd_n`), the block counts falling edges of the subsystem clock. On the second of them it takes the active-low busy and service-request lines into the current status word. This gives the subsystem time to decode the subaddress first, so it can report busy for selected subaddresses only.

It also handles the status effects of validated mode commands. A reset command emits a one-cycle low pulse to the subsystem and clears the fault latch. A dynamic-bus-control command raises an acceptance request, but only if the subsystem grants it. A transmit-vector command strobes the subsystem's vector latch. Two commands report the previously transmitted status word instead of the current one. A busy subsystem blocks data-word transfers, except for the synchronize-with-data and transmit-vector commands.

Top module: `rt_status_ctrl`

## Requirements
- R1: `status_word[k]` holds bit time k. Bits 4..8 carry `rt_addr` with its MSB at bit 4. Bit 9 is message error, bit 11 service request, bit 15 broadcast received, bit 16 busy, bit 17 subsystem flag, bit 18 dynamic bus control acceptance and bit 19 terminal flag. Bits 0..3, 10 and 12..14 are zero.
- R2: A falling edge of `cmd_n` clears the busy and service-request bits. On the second falling edge of `sub_clk` after that, bit 16 takes `!busy_n` and bit 11 takes `!srq_n`, one clock after the edge is seen.
- R3: `xfer_inhibit` is high while the busy bit is set. The exception is the last validated mode command of the current command, when its code is 5'b10001 (synchronize with data word) or 5'b10000 (transmit vector word).
- R4: The subsystem fault latch (bit 17) is set one clock after any cycle in which `ss_err_n` is low or `xfer_fail` is high.
- R5: The fault latch clears only on `rst_n` or on a valid mode command with code 5'b01000 (reset). If a set condition occurs in the same cycle, the set wins.
- R6: A valid mode command with code 5'b01000 drives `rt_reset_n` low for exactly the following clock cycle.
- R7: A valid mode command with code 5'b00000 raises `dbc_req` for one cycle and sets bit 18, but only when `dbc_acc_n` is low at that time. When `dbc_acc_n` is high, neither happens. Bit 18 clears at the next command.
- R8: While the last validated mode code of the current command is 5'b00010 or 5'b10010, `status_word` shows the last transmitted word. That word is captured from `status_word` at each cycle with `status_tx` high and is zero after reset.
- R9: A valid mode command with code 5'b10000 drives `vect_en_n` low for exactly the following clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Active-low decoded command strobe |
| sub_clk | input | 1 | Subsystem clock |
| busy_n | input | 1 | Subsystem busy, active low |
| srq_n | input | 1 | Subsystem service request, active low |
| ss_err_n | input | 1 | Subsystem error, active low |
| dbc_acc_n | input | 1 | Bus control acceptance grant, active low |
| xfer_fail | input | 1 | Data handshake failure pulse |
| mode_valid | input | 1 | Validated mode command strobe |
| mode_code | input | 5 | Mode code of that command |
| rt_addr | input | 5 | Terminal address |
| msg_err | input | 1 | Message error flag |
| bcast_rx | input | 1 | Broadcast received flag |
| term_flag | input | 1 | Terminal flag |
| status_tx | input | 1 | Status word being transmitted |
| status_word | output | 20 | Status word indexed by bit time |
| xfer_inhibit | output | 1 | Data-word transfer block |
| rt_reset_n | output | 1 | Subsystem reset pulse, active low |
| dbc_req | output | 1 | Bus control takeover request pulse |
| vect_en_n | output | 1 | Vector latch enable, active low |

## Verification
On every cycle, the embedded assertions check the following: the busy bit changes only at a command or subsystem-clock edge, the reset and vector strobes last one cycle, `dbc_req` never fires without a grant, and the fault latch follows its set inputs. They also check that the last-word register captures the presented word. The bench scenarios are needed for the rest. These are sampling at the second edge rather than the first, the exemption from the transfer block for the two mode codes, the fault latch clearing only by the reset mode, and the last-word substitution for the two commands that report the previous status.

// File: rtl/rtsw_pkg.sv
package rtsw_pkg;
  localparam int SW_BITS = 20;
  localparam int MODE_W  = 5;
  localparam int ADDR_W  = 5;
  localparam logic [MODE_W-1:0] MC_DBC       = 5'b00000;
  localparam logic [MODE_W-1:0] MC_TX_STATUS = 5'b00010;
  localparam logic [MODE_W-1:0] MC_RESET     = 5'b01000;
  localparam logic [MODE_W-1:0] MC_TX_VECTOR = 5'b10000;
  localparam logic [MODE_W-1:0] MC_SYNC_DATA = 5'b10001;
  localparam logic [MODE_W-1:0] MC_TX_LASTCMD = 5'b10010;
endpackage

// File: rtl/rtsw_sampler.sv
module rtsw_sampler #(
  parameter int EDGE_NUM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic sub_clk,
  input  logic busy_n,
  input  logic srq_n,
  output logic cmd_start,
  output logic busy_q,
  output logic srq_q
);
  localparam int CW = $clog2(EDGE_NUM + 1);

  logic cmd_d, sclk_d, armed_q, armed_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic busy_nxt, srq_nxt, sub_fall;

  assign cmd_start = cmd_d & ~cmd_n;
  assign sub_fall  = sclk_d & ~sub_clk;

  always_comb begin
    armed_nxt = armed_q;
    cnt_nxt   = cnt_q;
    busy_nxt  = busy_q;
    srq_nxt   = srq_q;
    if (cmd_start) begin
      armed_nxt = 1'b1;
      cnt_nxt   = '0;
      busy_nxt  = 1'b0;
      srq_nxt   = 1'b0;
    end else if (armed_q && sub_fall) begin
      if (cnt_q == CW'(EDGE_NUM - 1)) begin
        busy_nxt  = ~busy_n;
        srq_nxt   = ~srq_n;
        armed_nxt = 1'b0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d   <= 1'b1;
      sclk_d  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      srq_q   <= 1'b0;
    end else begin
      cmd_d   <= cmd_n;
      sclk_d  <= sub_clk;
      armed_q <= armed_nxt;
      cnt_q   <= cnt_nxt;
      busy_q  <= busy_nxt;
      srq_q   <= srq_nxt;
    end
  end

  // R2
  busy_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busy_q) |-> $past(cmd_start | sub_fall));
endmodule

// File: rtl/rtsw_fault.sv
module rtsw_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_err_n,
  input  logic xfer_fail,
  input  logic clr,
  output logic fault_q
);
  logic fault_nxt;

  always_comb begin
    fault_nxt = fault_q;
    if (!ss_err_n || xfer_fail) fault_nxt = 1'b1;
    else if (clr)               fault_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_nxt;
  end

  // R4
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_err_n || xfer_fail) |=> fault_q);
  // R5
  fault_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(clr));
endmodule

// File: rtl/rtsw_mode_ctl.sv
module rtsw_mode_ctl
  import rtsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              mode_valid,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              dbc_acc_n,
  output logic              mode_act,
  output logic [MODE_W-1:0] mode_q,
  output logic              rst_cmd,
  output logic              rst_pulse,
  output logic              dbc_req,
  output logic              dbc_bit,
  output logic              vec_pulse
);
  logic              act_nxt, dbc_bit_nxt;
  logic [MODE_W-1:0] mode_nxt;

  assign rst_cmd = mode_valid && (mode_code == MC_RESET);

  always_comb begin
    act_nxt     = mode_act;
    mode_nxt    = mode_q;
    dbc_bit_nxt = dbc_bit;
    if (cmd_start) begin
      act_nxt     = 1'b0;
      dbc_bit_nxt = 1'b0;
    end
    if (mode_valid) begin
      act_nxt  = 1'b1;
      mode_nxt = mode_code;
      if (mode_code == MC_DBC) dbc_bit_nxt = ~dbc_acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_act  <= 1'b0;
      mode_q    <= '0;
      dbc_bit   <= 1'b0;
      rst_pulse <= 1'b0;
      dbc_req   <= 1'b0;
      vec_pulse <= 1'b0;
    end else begin
      mode_act  <= act_nxt;
      mode_q    <= mode_nxt;
      dbc_bit   <= dbc_bit_nxt;
      rst_pulse <= rst_cmd;
      dbc_req   <= mode_valid && (mode_code == MC_DBC) && !dbc_acc_n;
      vec_pulse <= mode_valid && (mode_code == MC_TX_VECTOR);
    end
  end

  // R6
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse || $past(rst_cmd));
  // R7
  dbc_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbc_req |-> $past(!dbc_acc_n && mode_valid));
  // R9
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pulse |=> !vec_pulse || $past(mode_valid));
endmodule

// File: rtl/rt_status_ctrl.sv
module rt_status_ctrl
  import rtsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_n,
  input  logic              sub_clk,
  input  logic              busy_n,
  input  logic              srq_n,
  input  logic              ss_err_n,
  input  logic              dbc_acc_n,
  input  logic              xfer_fail,
  input  logic              mode_valid,
  input  logic [MODE_W-1:0] mode_code,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              msg_err,
  input  logic              bcast_rx,
  input  logic              term_flag,
  input  logic              status_tx,
  output logic [SW_BITS-1:0] status_word,
  output logic              xfer_inhibit,
  output logic              rt_reset_n,
  output logic              dbc_req,
  output logic              vect_en_n
);
  localparam int ADDR_BT = 4;

  logic cmd_start, busy_q, srq_q, fault_q, rst_cmd, rst_pulse, dbc_bit, vec_pulse, mode_act;
  logic [MODE_W-1:0]  mode_q;
  logic [SW_BITS-1:0] cur_word, last_q, last_nxt;
  logic use_last, exempt;

  rtsw_sampler #(.EDGE_NUM(2)) u_samp (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .sub_clk(sub_clk),
    .busy_n(busy_n), .srq_n(srq_n),
    .cmd_start(cmd_start), .busy_q(busy_q), .srq_q(srq_q));

  rtsw_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
    .mode_valid(mode_valid), .mode_code(mode_code), .dbc_acc_n(dbc_acc_n),
    .mode_act(mode_act), .mode_q(mode_q), .rst_cmd(rst_cmd),
    .rst_pulse(rst_pulse), .dbc_req(dbc_req), .dbc_bit(dbc_bit),
    .vec_pulse(vec_pulse));

  rtsw_fault u_fault (
    .clk(clk), .rst_n(rst_n), .ss_err_n(ss_err_n), .xfer_fail(xfer_fail),
    .clr(rst_cmd), .fault_q(fault_q));

  always_comb begin
    cur_word = '0;
    for (int i = 0; i < ADDR_W; i++) cur_word[ADDR_BT + i] = rt_addr[ADDR_W - 1 - i];
    cur_word[9]  = msg_err;
    cur_word[11] = srq_q;
    cur_word[15] = bcast_rx;
    cur_word[16] = busy_q;
    cur_word[17] = fault_q;
    cur_word[18] = dbc_bit;
    cur_word[19] = term_flag;
  end

  assign use_last     = mode_act && (mode_q == MC_TX_STATUS || mode_q == MC_TX_LASTCMD);
  assign exempt       = mode_act && (mode_q == MC_SYNC_DATA || mode_q == MC_TX_VECTOR);
  assign status_word  = use_last ? last_q : cur_word;
  assign xfer_inhibit = busy_q && !exempt;
  assign rt_reset_n   = ~rst_pulse;
  assign vect_en_n    = ~vec_pulse;

  always_comb begin
    last_nxt = last_q;
    if (status_tx) last_nxt = status_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_nxt;
  end

  // R8
  last_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_tx |=> last_q == $past(status_word));
  // R3
  inhibit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_inhibit |-> busy_q);
endmodule

// File: tb/rt_status_ctrl_tb.sv
module rt_status_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_n = 1'b1, sub_clk = 1'b1, busy_n = 1'b1, srq_n = 1'b1, ss_err_n = 1'b1;
  logic dbc_acc_n = 1'b1, xfer_fail = 1'b0, mode_valid = 1'b0;
  logic [4:0] mode_code = 5'd0, rt_addr = 5'b10110;
  logic msg_err = 1'b0, bcast_rx = 1'b0, term_flag = 1'b0, status_tx = 1'b0;
  logic [19:0] status_word;
  logic xfer_inhibit, rt_reset_n, dbc_req, vect_en_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rt_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .sub_clk(sub_clk), .busy_n(busy_n),
    .srq_n(srq_n), .ss_err_n(ss_err_n), .dbc_acc_n(dbc_acc_n), .xfer_fail(xfer_fail),
    .mode_valid(mode_valid), .mode_code(mode_code), .rt_addr(rt_addr),
    .msg_err(msg_err), .bcast_rx(bcast_rx), .term_flag(term_flag),
    .status_tx(status_tx), .status_word(status_word), .xfer_inhibit(xfer_inhibit),
    .rt_reset_n(rt_reset_n), .dbc_req(dbc_req), .vect_en_n(vect_en_n));

  // behavioural reference state
  int m_cmdq, m_sq, m_armed, m_edges, m_busy, m_srq, m_fault, m_dbc, m_act, m_mode;
  int m_rstp, m_req, m_vec;
  logic [19:0] m_last;

  function automatic logic [19:0] exp_word();
    logic [19:0] w = '0;
    if (m_act != 0 && (m_mode == 2 || m_mode == 18)) return m_last;
    for (int i = 0; i < 5; i++) w[4 + i] = rt_addr[4 - i];
    w[9] = msg_err; w[11] = (m_srq != 0); w[15] = bcast_rx; w[16] = (m_busy != 0);
    w[17] = (m_fault != 0); w[18] = (m_dbc != 0); w[19] = term_flag;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmdq = 1; m_sq = 1; m_armed = 0; m_edges = 0; m_busy = 0; m_srq = 0;
      m_fault = 0; m_dbc = 0; m_act = 0; m_mode = 0; m_rstp = 0; m_req = 0; m_vec = 0;
      m_last = '0;
    end else begin : step
      int cf, sf;
      cf = (m_cmdq == 1 && cmd_n == 1'b0);
      sf = (m_sq == 1 && sub_clk == 1'b0);
      if (status_tx) m_last = exp_word();
      if (!ss_err_n || xfer_fail) m_fault = 1;
      else if (mode_valid && mode_code == 5'd8) m_fault = 0;
      m_rstp = (mode_valid && mode_code == 5'd8);
      m_req  = (mode_valid && mode_code == 5'd0 && !dbc_acc_n);
      m_vec  = (mode_valid && mode_code == 5'd16);
      if (cf != 0) begin
        m_armed = 1; m_edges = 0; m_busy = 0; m_srq = 0; m_act = 0; m_dbc = 0;
      end else if (sf != 0 && m_armed != 0) begin
        m_edges++;
        if (m_edges == 2) begin m_busy = !busy_n; m_srq = !srq_n; m_armed = 0; end
      end
      if (mode_valid) begin
        m_act = 1; m_mode = mode_code;
        if (mode_code == 5'd0) m_dbc = !dbc_acc_n;
      end
      m_cmdq = cmd_n; m_sq = sub_clk;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (!done) begin : cmp
    logic [19:0] ew;
    int ex;
    ew = exp_word();
    ex = (m_act != 0 && m_busy != 0 && (m_mode == 17 || m_mode == 16)) ? 0 : m_busy;
    chk(status_word[16] == ew[16], "R2 busy bit", 32'(status_word[16]), 32'(ew[16]));
    chk(status_word[11] == ew[11], "R2 srq bit", 32'(status_word[11]), 32'(ew[11]));
    chk(status_word[17] == ew[17], "R4 fault bit", 32'(status_word[17]), 32'(ew[17]));
    chk(status_word[18] == ew[18], "R7 dbc bit", 32'(status_word[18]), 32'(ew[18]));
    chk(status_word == ew, "R1 R8 word", 32'(status_word), 32'(ew));
    chk(xfer_inhibit == (ex != 0), "R3 inhibit", 32'(xfer_inhibit), 32'(ex));
    chk(rt_reset_n == (m_rstp == 0), "R6 reset", 32'(rt_reset_n), 32'(m_rstp == 0));
    chk(dbc_req == (m_req != 0), "R7 dbc_req", 32'(dbc_req), 32'(m_req));
    chk(vect_en_n == (m_vec == 0), "R9 vect_en_n", 32'(vect_en_n), 32'(m_vec == 0));
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic cmd(); cmd_n = 1'b0; tick(); tick(); cmd_n = 1'b1; tick(); endtask
  task automatic sfall(); sub_clk = 1'b0; tick(); tick(); sub_clk = 1'b1; tick(); tick(); endtask
  task automatic mode(input logic [4:0] c);
    mode_code = c; mode_valid = 1'b1; tick(); mode_valid = 1'b0; tick(); tick();
  endtask

  logic [19:0] saved;
  int seen;

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    chk(status_word == 20'h000D0, "R1 reset word", 32'(status_word), 32'h000D0);
    tick();
    // busy low on the second sub edge
    cmd(); busy_n = 1'b0; sfall(); sfall(); busy_n = 1'b1;
    @(negedge clk);
    chk(status_word[16] == 1'b1, "R2 busy set", 32'(status_word[16]), 1);
    chk(xfer_inhibit == 1'b1, "R3 inhibit on busy", 32'(xfer_inhibit), 1);
    tick(); mode(5'b10001);
    @(negedge clk);
    chk(xfer_inhibit == 1'b0, "R3 sync-data exempt", 32'(xfer_inhibit), 0);
    tick();
    // busy only at first edge, srq at second
    cmd(); busy_n = 1'b0; sfall(); busy_n = 1'b1; srq_n = 1'b0; sfall(); srq_n = 1'b1;
    msg_err = 1'b1; term_flag = 1'b1;
    @(negedge clk);
    chk(status_word[16] == 1'b0, "R2 first edge ignored", 32'(status_word[16]), 0);
    chk(status_word[11] == 1'b1, "R2 srq set", 32'(status_word[11]), 1);
    saved = status_word;
    tick(); status_tx = 1'b1; tick(); status_tx = 1'b0; msg_err = 1'b0; term_flag = 1'b0;
    cmd(); mode(5'b00010);
    @(negedge clk);
    chk(status_word == saved, "R8 last word", 32'(status_word), 32'(saved));
    tick(); mode(5'b10010);
    // fault by ss_err, survives a new command, cleared by reset mode
    ss_err_n = 1'b0; tick(); ss_err_n = 1'b1; tick();
    cmd(); sfall(); sfall();
    @(negedge clk);
    chk(status_word[17] == 1'b1, "R5 fault held", 32'(status_word[17]), 1);
    tick(); mode_code = 5'b01000; mode_valid = 1'b1; tick(); mode_valid = 1'b0;
    @(negedge clk);
    chk(rt_reset_n == 1'b0, "R6 reset low", 32'(rt_reset_n), 0);
    chk(status_word[17] == 1'b0, "R5 fault cleared", 32'(status_word[17]), 0);
    tick();
    xfer_fail = 1'b1; tick(); xfer_fail = 1'b0;
    @(negedge clk);
    chk(status_word[17] == 1'b1, "R4 handshake fault", 32'(status_word[17]), 1);
    tick();
    ss_err_n = 1'b0; mode_code = 5'b01000; mode_valid = 1'b1; tick();
    mode_valid = 1'b0; ss_err_n = 1'b1;
    @(negedge clk);
    chk(status_word[17] == 1'b1, "R5 set wins", 32'(status_word[17]), 1);
    tick();
    // dynamic bus control
    cmd(); dbc_acc_n = 1'b1; mode(5'b00000);
    @(negedge clk);
    chk(status_word[18] == 1'b0, "R7 no grant", 32'(status_word[18]), 0);
    tick(); cmd(); dbc_acc_n = 1'b0;
    mode_code = 5'b00000; mode_valid = 1'b1; tick(); mode_valid = 1'b0;
    @(negedge clk);
    chk(dbc_req == 1'b1, "R7 req pulse", 32'(dbc_req), 1);
    chk(status_word[18] == 1'b1, "R7 bit set", 32'(status_word[18]), 1);
    tick(); dbc_acc_n = 1'b1; cmd();
    // vector
    busy_n = 1'b0; sfall(); sfall(); busy_n = 1'b1;
    mode_code = 5'b10000; mode_valid = 1'b1; tick(); mode_valid = 1'b0;
    @(negedge clk);
    chk(vect_en_n == 1'b0, "R9 vector strobe", 32'(vect_en_n), 0);
    chk(xfer_inhibit == 1'b0, "R3 vector exempt", 32'(xfer_inhibit), 0);
    tick(); tick();
    @(negedge clk);
    chk(vect_en_n == 1'b1, "R9 strobe ends", 32'(vect_en_n), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seen = 0;
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule